// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. An external enable pulses sixteen times per bit period (the oversampling rate is a parameter). The receiver uses it to find the falling edge of a start bit, confirm that bit at its midpoint and then sample each later bit at its centre. Three small configuration inputs set the frame shape: character length, parity mode and stop-bit count. They are expected to stay stable while a frame is in flight.

Each character is delivered on `rx_data` with a one-cycle `rx_valid` strobe. Three flags travel with it: parity error, framing error and line break. A short low glitch on the idle line is dropped without any output. If the line stays low through the whole configured frame, the receiver reports a break as a single all-zero character. It then sits still until the line goes high again. The block has a synchronizer, the sampling state machine and the flag generation. Buffering, bus access and interrupt handling sit outside it.

Top module: `serial_char_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `err_parity`, `err_frame` and `brk_det` are all zero.
- R2: `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits arrive least significant first. Bits of `rx_data` above the selected length read as zero.
- R3: `cfg_par` code 1 selects odd parity and code 2 selects even parity. In those modes one parity bit follows the data, and `err_parity` is set when that bit does not give the selected sense over the data bits. Codes 0 and 3 mean no parity bit, and `err_parity` stays zero.
- R4: A low level at the middle of the first stop bit sets `err_frame`, and the received data is still delivered. After such a character the receiver waits for a high line before it looks for a new start bit.
- R5: `cfg_stop` code 0 means 1 stop bit, code 1 means 1.5 and codes 2 and 3 mean 2. Only the first stop bit is sampled, so frames with one stop bit can follow each other with no idle gap and each is received.
- R6: A low pulse on the idle line that is high again at the midpoint of the start bit produces no character. A following valid frame is received correctly.
- R7: If the data bits, the parity bit and the first stop bit are all low, and the line stays low to the end of the configured stop time, exactly one character is delivered: data 0x00, with `brk_det` and `err_frame` set and `err_parity` clear. No further character is delivered until the line has gone high and a new frame starts.
- R8: An all-zero character with a high stop bit is an ordinary character with no flags. An all-zero frame with a low first stop bit that goes high before the end of the configured stop time gives `err_frame` without `brk_det`.
- R9: `rx_valid` is high for exactly one clock per character. The data and flags hold their values until the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling enable, OVS pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_par | input | 2 | Parity mode (1 odd, 2 even, 0/3 none) |
| cfg_stop | input | 2 | Stop bit code (0 = 1, 1 = 1.5, 2/3 = 2) |
| rx_data | output | 8 | Received character, zero-filled above the length |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| err_parity | output | 1 | Parity error for the current character |
| err_frame | output | 1 | Framing error for the current character |
| brk_det | output | 1 | Line break indication for the current character |

## Verification
Three kinds of internal fault show up in different ways:

- A bit counter or length decode that is off by one shifts or truncates the character. It shows on `rx_data` and the parity flag at the very next strobe.
- A wrong midpoint count either lets short glitches through as spurious characters, or drifts the sampling point until later bits are misread. Both show within one or two frames.
- An error in the break or wait-for-high path shows as a missing break character, a second character during a held-low line, or a receiver that never re-arms. So the bench holds the line low well past the frame, then sends an ordinary character and checks both results.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK,
    ST_WAITHI
  } rx_state_e;

  localparam logic [1:0] PAR_ODD  = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;

  // Raw result of one frame, handed from the sampler to the flag stage
  typedef struct packed {
    logic [7:0] data;
    logic       pbit;
    logic       stop_low;
    logic       brk;
  } rx_raw_t;

  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic par_on(input logic [1:0] mode);
    return (mode == PAR_ODD) || (mode == PAR_EVEN);
  endfunction

endpackage

// File: rtl/rxc_sync.sv
module rxc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxc_frame.sv
module rxc_frame
  import rxc_pkg::*;
#(
  parameter int OVS = 16,
  localparam int HALF = OVS / 2,
  localparam int CW = $clog2(2 * OVS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxs,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic [1:0] cfg_stop,
  output logic       emit,
  output rx_raw_t    raw
);
  rx_state_e      state;
  logic [CW-1:0]  cnt;
  logic [2:0]     bidx;
  logic [7:0]     sh;
  logic           allz;
  logic           pbit;
  logic [CW-1:0]  brk_lim;
  logic           bit_mid;

  // Ticks from the middle of the first stop bit to the end of the frame
  always_comb begin
    case (cfg_stop)
      2'd0:    brk_lim = CW'(HALF);
      2'd1:    brk_lim = CW'(OVS);
      default: brk_lim = CW'(OVS + HALF);
    endcase
  end

  assign bit_mid = (cnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
      allz  <= 1'b0;
      pbit  <= 1'b0;
      emit  <= 1'b0;
      raw   <= '0;
    end else begin
      emit <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!rxs) begin
              state <= ST_START;
              cnt   <= CW'(1);
            end
          end
          ST_START: begin
            if (cnt == CW'(HALF - 1)) begin
              if (rxs) begin
                state <= ST_IDLE;
              end else begin
                state <= ST_DATA;
                cnt   <= '0;
                bidx  <= '0;
                sh    <= '0;
                allz  <= 1'b1;
                pbit  <= 1'b0;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_DATA: begin
            if (bit_mid) begin
              cnt      <= '0;
              sh[bidx] <= rxs;
              if (rxs) allz <= 1'b0;
              if ({1'b0, bidx} == data_len(cfg_len) - 4'd1)
                state <= par_on(cfg_par) ? ST_PAR : ST_STOP;
              else
                bidx <= bidx + 3'd1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_PAR: begin
            if (bit_mid) begin
              cnt   <= '0;
              pbit  <= rxs;
              if (rxs) allz <= 1'b0;
              state <= ST_STOP;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_STOP: begin
            if (bit_mid) begin
              cnt <= '0;
              if (rxs) begin
                emit  <= 1'b1;
                raw   <= '{data: sh, pbit: pbit, stop_low: 1'b0, brk: 1'b0};
                state <= ST_IDLE;
              end else if (allz) begin
                state <= ST_BRK;
              end else begin
                emit  <= 1'b1;
                raw   <= '{data: sh, pbit: pbit, stop_low: 1'b1, brk: 1'b0};
                state <= ST_WAITHI;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_BRK: begin
            if (rxs) begin
              emit  <= 1'b1;
              raw   <= '{data: sh, pbit: pbit, stop_low: 1'b1, brk: 1'b0};
              state <= ST_IDLE;
            end else if (cnt == brk_lim - CW'(1)) begin
              emit  <= 1'b1;
              raw   <= '{data: 8'h00, pbit: 1'b0, stop_low: 1'b1, brk: 1'b1};
              state <= ST_WAITHI;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_WAITHI: begin
            if (rxs) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: while waiting for the line to rise, nothing is emitted
  assert_waithi_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITHI) |=> !emit);

  // R7: a break result is an all-zero character carrying a stop error
  assert_brk_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (emit && raw.brk) |-> (raw.data == 8'h00 && raw.stop_low));

  // R2: five-bit characters never carry upper bits
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (emit && cfg_len == 2'd0) |-> (raw.data[7:5] == 3'b000));
endmodule

// File: rtl/rxc_status.sv
module rxc_status
  import rxc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       emit,
  input  rx_raw_t    raw,
  input  logic [1:0] cfg_par,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       err_parity,
  output logic       err_frame,
  output logic       brk_det
);
  logic want_pbit;
  logic perr_now;

  // Parity bit that would give the selected sense over the data bits
  assign want_pbit = (^raw.data) ^ (cfg_par == PAR_ODD);
  assign perr_now  = par_on(cfg_par) && !raw.brk && (raw.pbit != want_pbit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      brk_det    <= 1'b0;
    end else begin
      rx_valid <= emit;
      if (emit) begin
        rx_data    <= raw.data;
        err_parity <= perr_now;
        err_frame  <= raw.stop_low;
        brk_det    <= raw.brk;
      end
    end
  end

  // R9: the strobe never lasts two cycles
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R3: no parity slot means no parity error
  assert_noparity_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !par_on(cfg_par)) |-> !err_parity);

  // R7: a break always comes with a framing error and zero data
  assert_brk_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && brk_det) |-> (err_frame && !err_parity && rx_data == 8'h00));
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import rxc_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       rx_line,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic [1:0] cfg_stop,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       err_parity,
  output logic       err_frame,
  output logic       brk_det
);
  logic    rxs;
  logic    emit;
  rx_raw_t raw;

  rxc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_line),
    .q   (rxs)
  );

  rxc_frame #(.OVS(OVS)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick),
    .rxs      (rxs),
    .cfg_len  (cfg_len),
    .cfg_par  (cfg_par),
    .cfg_stop (cfg_stop),
    .emit     (emit),
    .raw      (raw)
  );

  rxc_status u_status (
    .clk        (clk),
    .rst        (rst),
    .emit       (emit),
    .raw        (raw),
    .cfg_par    (cfg_par),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .brk_det    (brk_det)
  );
endmodule

// File: tb/tb_serial_char_rx.sv
module tb_serial_char_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int OVS        = 16;
  localparam int BITC       = TDIV * OVS;
  localparam int WDOG       = 150000;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par;
    logic [1:0] stp;
    logic [7:0] data;
    logic       flip;
    logic       stopv;
    logic [7:0] e_data;
    logic       e_perr;
    logic       e_ferr;
    logic       e_brk;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 2'd0, 2'd0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0},
    '{2'd1, 2'd2, 2'd0, 8'h2C, 1'b0, 1'b1, 8'h2C, 1'b0, 1'b0, 1'b0},
    '{2'd2, 2'd1, 2'd1, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
    '{2'd3, 2'd2, 2'd2, 8'h81, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0},
    '{2'd3, 2'd1, 2'd0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},
    '{2'd3, 2'd0, 2'd0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0},
    '{2'd0, 2'd1, 2'd0, 8'h13, 1'b0, 1'b0, 8'h13, 1'b0, 1'b1, 1'b0},
    '{2'd3, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd2, 2'd2, 2'd2, 8'h7F, 1'b1, 1'b1, 8'h7F, 1'b1, 1'b0, 1'b0},
    '{2'd1, 2'd1, 2'd1, 8'h3F, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0, 1'b0},
    '{2'd3, 2'd0, 2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{2'd1, 2'd3, 2'd0, 8'h2A, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b0, 1'b0},
    '{2'd3, 2'd2, 2'd3, 8'hC3, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       err_parity;
  logic       err_frame;
  logic       brk_det;

  int n_checks = 0;
  int n_fail   = 0;
  int vcount   = 0;
  int long_strobes = 0;
  logic       prev_valid = 1'b0;
  logic [7:0] first_data = '0;
  logic [7:0] last_data  = '0;
  logic [1:0] tdiv = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'(TDIV - 1));

  serial_char_rx #(.OVS(OVS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
    .err_frame(err_frame), .brk_det(brk_det)
  );

  // Strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (prev_valid) long_strobes++;
      vcount++;
      first_data = last_data;
      last_data  = rx_data;
    end
    prev_valid = rx_valid;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] len, input logic [1:0] par,
                            input logic [1:0] stp, input logic [7:0] data,
                            input logic flip, input logic stopv, input int gap);
    int nb;
    logic [7:0] m;
    logic p;
    nb = 5 + int'(len);
    m = data & ((8'h1 << nb) - 8'h1);
    hold(1'b0, BITC);
    for (int i = 0; i < nb; i++) hold(m[i], BITC);
    if (par == 2'd1 || par == 2'd2) begin
      p = (^m) ^ (par == 2'd1) ^ flip;
      hold(p, BITC);
    end
    hold(stopv, BITC);
    if (stp == 2'd1) hold(1'b1, BITC / 2);
    else if (stp >= 2'd2) hold(1'b1, BITC);
    if (gap > 0) hold(1'b1, BITC * gap);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", rx_valid, 0);
    check("R1 data", rx_data, 0);
    check("R1 flags", {err_parity, err_frame, brk_det}, 0);
    hold(1'b1, BITC);

    // Table walk: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      cfg_len = VECS[v].len;
      cfg_par = VECS[v].par;
      cfg_stop = VECS[v].stp;
      base = vcount;
      send_frame(VECS[v].len, VECS[v].par, VECS[v].stp, VECS[v].data,
                 VECS[v].flip, VECS[v].stopv, 1);
      check("R2 R5 one char per frame", vcount - base, 1);
      check("R2 data", last_data, VECS[v].e_data);
      check("R3 parity flag", err_parity, VECS[v].e_perr);
      check("R4 R8 frame flag", err_frame, VECS[v].e_ferr);
      check("R8 break flag", brk_det, VECS[v].e_brk);
    end

    // R6: short glitch is rejected, next frame still received
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd0;
    base = vcount;
    hold(1'b0, 16);
    hold(1'b1, 3 * BITC);
    check("R6 glitch ignored", vcount - base, 0);
    send_frame(2'd3, 2'd0, 2'd0, 8'h96, 1'b0, 1'b1, 1);
    check("R6 frame after glitch", vcount - base, 1);
    check("R6 data after glitch", last_data, 8'h96);

    // R5: back-to-back frames with one stop bit
    base = vcount;
    send_frame(2'd3, 2'd2, 2'd0, 8'h3A, 1'b0, 1'b1, 0);
    send_frame(2'd3, 2'd2, 2'd0, 8'hC5, 1'b0, 1'b1, 1);
    check("R5 back-to-back count", vcount - base, 2);
    check("R5 first data", first_data, 8'h3A);
    check("R5 second data", last_data, 8'hC5);
    check("R5 second parity", err_parity, 0);

    // R7: break then re-arm
    cfg_par = 2'd0; cfg_stop = 2'd0;
    base = vcount;
    hold(1'b0, 14 * BITC);
    check("R7 single break char", vcount - base, 1);
    check("R7 break data", last_data, 8'h00);
    check("R7 break flag", brk_det, 1);
    check("R7 frame flag", err_frame, 1);
    check("R7 parity clear", err_parity, 0);
    hold(1'b1, 2 * BITC);
    check("R7 nothing on release", vcount - base, 1);
    send_frame(2'd3, 2'd0, 2'd0, 8'h5A, 1'b0, 1'b1, 1);
    check("R7 re-arm count", vcount - base, 2);
    check("R7 re-arm data", last_data, 8'h5A);
    check("R7 re-arm break clear", brk_det, 0);

    // R9: every strobe lasted one cycle
    check("R9 strobe width", long_strobes, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule